// File: doc/BRIEF.md
# Run-Time Programmable Sum-of-Products Logic Array

This block is a two-level logic array whose contents are written at run time. It holds one row per product term. Each row has an AND-plane part, which gives a two-bit literal code for every input, and an OR-plane part, which has one connect bit for every output. Once the rows are loaded, each output is the OR of the product terms connected to it. The outputs follow the inputs combinationally, and one product term can drive any number of outputs.

Rows are written through a one-cycle register-write port. The write enable, the row number and a data word are sampled on a rising clock edge. A separate read port returns any stored row combinationally.

An elaboration parameter selects between two array variants:
- In the general variant (`PAL_MODE = 0`), every output may use every term.
- In the restricted variant (`PAL_MODE = 1`), each output owns a fixed block of `TERMS_PER_OUT` consecutive terms. Term `t` belongs to output `t / TERMS_PER_OUT`. Connect bits that fall outside a term's owner are discarded when the row is written.

Top module: `sop_logic_array`

## Requirements
- R1: Input `i` of a term is coded by data bits `[2i+1:2i]`. Code `10` requires the input to be 1, `01` requires it to be 0, and `00` leaves the input out of the term.
- R2: Code `11` on any input forces that product term to 0 for every input pattern.
- R3: A term with every input coded `00` evaluates to 1. An output with no connected terms is 0.
- R4: Data bit `2*N_IN + j` set in a row connects that term to output `j`. One term may feed several outputs at once, and each output is the OR of its connected terms.
- R5: The outputs follow a change on `in_vec` without waiting for a clock edge.
- R6: A write takes effect on the rising edge where `cfg_we` is 1, and stores `cfg_data` into row `cfg_row`. Before that edge the row keeps its old value. While `cfg_we` is 0, edges change no row.
- R7: `rd_data` returns the stored word of row `rd_row` combinationally, with the same bit layout as `cfg_data`.
- R8: With `PAL_MODE = 1`, a write keeps only the connect bit of output `t / TERMS_PER_OUT` for row `t`. The other connect bits are stored as 0, read back as 0, and never affect any output.
- R9: When `rst_n` is low at a rising edge, the edge clears every row. After that edge every output is 0 and every row reads back 0.
- R10: When loaded with the terms A, B'C', AC', AB and B'C, with A, B and C on inputs 0, 1 and 2, the array produces these four functions: F0 = A + B'C', F1 = AC' + AB, F2 = B'C' + AB and F3 = B'C + A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Active-low synchronous clear of the whole matrix |
| cfg_we | input | 1 | Row write enable |
| cfg_row | input | ROW_W | Row (product term) to write |
| cfg_data | input | 2*N_IN+N_OUT | Literal codes in the low bits, connect bits in the high bits |
| rd_row | input | ROW_W | Row to read back |
| rd_data | output | 2*N_IN+N_OUT | Stored word of row `rd_row` |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Sum-of-products outputs |

## Verification
The bench builds two copies of the array, both with three inputs and four outputs:
- a general copy with eight terms;
- a restricted copy with sixteen terms in four-term groups.

Three inputs allow every input pattern to be swept after each reprogramming, so each output is compared against a bench model at all eight points. The restricted copy gives every output a full group of its own terms. This makes the discarding of cross-group connect bits visible at both the read port and the outputs.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

   typedef logic [1:0] lit_code_t;

   localparam lit_code_t LIT_FREE = 2'b00;
   localparam lit_code_t LIT_NEG  = 2'b01;
   localparam lit_code_t LIT_POS  = 2'b10;
   localparam lit_code_t LIT_KILL = 2'b11;

   // Upper bit demands a 1 on the input, lower bit demands a 0; both => never.
   function automatic logic lit_pass(input lit_code_t code, input logic x);
      return !(code[1] && !x) && !(code[0] && x);
   endfunction

endpackage

// File: rtl/sop_term_store.sv
module sop_term_store #(
   parameter int N_IN          = 4,
   parameter int N_TERM        = 16,
   parameter int N_OUT         = 4,
   parameter bit PAL_MODE      = 1'b0,
   parameter int TERMS_PER_OUT = 4,
   parameter int ROW_W         = 4,
   parameter int AND_W         = 2 * N_IN,
   parameter int DATA_W        = AND_W + N_OUT
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ROW_W-1:0]          wr_row,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic [ROW_W-1:0]          rd_row,
   output logic [DATA_W-1:0]         rd_data,
   output logic [N_TERM*AND_W-1:0]   and_flat,
   output logic [N_TERM*N_OUT-1:0]   or_flat
);

   logic [N_TERM-1:0][DATA_W-1:0] row_q;

   function automatic logic [N_OUT-1:0] keep_mask(input int t);
      logic [N_OUT-1:0] m;
      m = '0;
      for (int j = 0; j < N_OUT; j++) begin
         m[j] = PAL_MODE ? ((t / TERMS_PER_OUT) == j) : 1'b1;
      end
      return m;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q <= '0;
      end else if (wr_en) begin
         for (int t = 0; t < N_TERM; t++) begin
            if (int'(wr_row) == t) begin
               row_q[t] <= {wr_data[DATA_W-1:AND_W] & keep_mask(t),
                            wr_data[AND_W-1:0]};
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int t = 0; t < N_TERM; t++) begin
         if (int'(rd_row) == t) rd_data = row_q[t];
      end
   end

   for (genvar t = 0; t < N_TERM; t++) begin : g_flat
      assign and_flat[t*AND_W +: AND_W] = row_q[t][AND_W-1:0];
      assign or_flat[t*N_OUT +: N_OUT]  = row_q[t][DATA_W-1:AND_W];
   end

   // R6: a write lands its literal codes in the addressed row on the next edge
   assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_row) < N_TERM) |=>
         (row_q[$past(wr_row)][AND_W-1:0] == $past(wr_data[AND_W-1:0])));

   // R6: without a write enable nothing in the matrix moves
   assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(row_q));

   if (PAL_MODE) begin : g_pal_guard
      for (genvar t = 0; t < N_TERM; t++) begin : g_row
         // R8: connect bits outside the owning output stay clear
         assert_foreign_or_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (row_q[t][DATA_W-1:AND_W] & ~keep_mask(t)) == '0);
      end
   end

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
   import sop_array_pkg::*;
#(
   parameter int N_IN   = 4,
   parameter int N_TERM = 16,
   parameter int AND_W  = 2 * N_IN
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_IN-1:0]         in_vec,
   input  logic [N_TERM*AND_W-1:0] and_flat,
   output logic [N_TERM-1:0]       term_vec
);

   always_comb begin
      for (int t = 0; t < N_TERM; t++) begin
         term_vec[t] = 1'b1;
         for (int i = 0; i < N_IN; i++) begin
            term_vec[t] &= lit_pass(lit_code_t'(and_flat[t*AND_W + 2*i +: 2]), in_vec[i]);
         end
      end
   end

   logic [N_TERM-1:0] kill_any;
   logic [N_TERM-1:0] all_free;

   always_comb begin
      for (int t = 0; t < N_TERM; t++) begin
         kill_any[t] = 1'b0;
         for (int i = 0; i < N_IN; i++) begin
            kill_any[t] |= (and_flat[t*AND_W + 2*i +: 2] == LIT_KILL);
         end
         all_free[t] = (and_flat[t*AND_W +: AND_W] == '0);
      end
   end

   for (genvar t = 0; t < N_TERM; t++) begin : g_chk
      // R2: a kill code anywhere in the term pins it low
      assert_kill_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
         kill_any[t] |-> !term_vec[t]);
      // R3: a term with no participating inputs is a constant 1
      assert_free_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
         all_free[t] |-> term_vec[t]);
   end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
   parameter int N_TERM        = 16,
   parameter int N_OUT         = 4,
   parameter bit PAL_MODE      = 1'b0,
   parameter int TERMS_PER_OUT = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_TERM-1:0]       term_vec,
   input  logic [N_TERM*N_OUT-1:0] or_flat,
   output logic [N_OUT-1:0]        out_vec
);

   if (PAL_MODE) begin : g_pal
      // Each OR gate only sees its own block of terms.
      for (genvar j = 0; j < N_OUT; j++) begin : g_out
         logic [TERMS_PER_OUT-1:0] hit;
         for (genvar k = 0; k < TERMS_PER_OUT; k++) begin : g_term
            localparam int T = j * TERMS_PER_OUT + k;
            assign hit[k] = term_vec[T] & or_flat[T*N_OUT + j];
         end
         assign out_vec[j] = |hit;
      end
   end else begin : g_pla
      always_comb begin
         for (int j = 0; j < N_OUT; j++) begin
            out_vec[j] = 1'b0;
            for (int t = 0; t < N_TERM; t++) begin
               out_vec[j] |= term_vec[t] & or_flat[t*N_OUT + j];
            end
         end
      end
   end

   logic [N_OUT-1:0] col_used;
   always_comb begin
      for (int j = 0; j < N_OUT; j++) begin
         col_used[j] = 1'b0;
         for (int t = 0; t < N_TERM; t++) col_used[j] |= or_flat[t*N_OUT + j];
      end
   end

   for (genvar j = 0; j < N_OUT; j++) begin : g_chk
      // R3: an output with an empty column never rises
      assert_empty_column_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !col_used[j] |-> !out_vec[j]);
   end

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array #(
   parameter int N_IN          = 4,
   parameter int N_TERM        = 16,
   parameter int N_OUT         = 4,
   parameter bit PAL_MODE      = 1'b0,
   parameter int TERMS_PER_OUT = 4,
   localparam int ROW_W        = (N_TERM > 1) ? $clog2(N_TERM) : 1,
   localparam int AND_W        = 2 * N_IN,
   localparam int DATA_W       = AND_W + N_OUT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ROW_W-1:0]  cfg_row,
   input  logic [DATA_W-1:0] cfg_data,
   input  logic [ROW_W-1:0]  rd_row,
   output logic [DATA_W-1:0] rd_data,
   input  logic [N_IN-1:0]   in_vec,
   output logic [N_OUT-1:0]  out_vec
);

   if (N_IN < 1 || N_TERM < 1 || N_OUT < 1) begin : g_bad_size
      $error("sop_logic_array: sizes must be positive");
   end
   if (PAL_MODE && (TERMS_PER_OUT < 1 || N_TERM < N_OUT * TERMS_PER_OUT)) begin : g_bad_pal
      $error("sop_logic_array: restricted mode needs N_OUT*TERMS_PER_OUT terms");
   end

   logic [N_TERM*AND_W-1:0] and_flat;
   logic [N_TERM*N_OUT-1:0] or_flat;
   logic [N_TERM-1:0]       term_vec;

   sop_term_store #(
      .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .PAL_MODE(PAL_MODE),
      .TERMS_PER_OUT(TERMS_PER_OUT), .ROW_W(ROW_W), .AND_W(AND_W), .DATA_W(DATA_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_row(cfg_row), .wr_data(cfg_data),
      .rd_row(rd_row), .rd_data(rd_data),
      .and_flat(and_flat), .or_flat(or_flat)
   );

   sop_and_plane #(
      .N_IN(N_IN), .N_TERM(N_TERM), .AND_W(AND_W)
   ) u_and (
      .clk(clk), .rst_n(rst_n),
      .in_vec(in_vec), .and_flat(and_flat), .term_vec(term_vec)
   );

   sop_or_plane #(
      .N_TERM(N_TERM), .N_OUT(N_OUT), .PAL_MODE(PAL_MODE), .TERMS_PER_OUT(TERMS_PER_OUT)
   ) u_or (
      .clk(clk), .rst_n(rst_n),
      .term_vec(term_vec), .or_flat(or_flat), .out_vec(out_vec)
   );

endmodule

// File: tb/sop_logic_array_bench.sv
`timescale 1ns/100ps
module sop_logic_array_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // general copy: 3 inputs, 8 terms, 4 outputs
   logic       a_we = 0;
   logic [2:0] a_row = '0, a_rd = '0;
   logic [9:0] a_data = '0, a_rdd;
   logic [2:0] a_in = '0;
   logic [3:0] a_out;

   // restricted copy: 3 inputs, 16 terms, 4 outputs, groups of 4
   logic       b_we = 0;
   logic [3:0] b_row = '0, b_rd = '0;
   logic [9:0] b_data = '0, b_rdd;
   logic [2:0] b_in = '0;
   logic [3:0] b_out;

   sop_logic_array #(.N_IN(3), .N_TERM(8), .N_OUT(4), .PAL_MODE(1'b0)) u_sop_logic_array (
      .clk(clk), .rst_n(rst_n), .cfg_we(a_we), .cfg_row(a_row), .cfg_data(a_data),
      .rd_row(a_rd), .rd_data(a_rdd), .in_vec(a_in), .out_vec(a_out));

   sop_logic_array #(.N_IN(3), .N_TERM(16), .N_OUT(4), .PAL_MODE(1'b1), .TERMS_PER_OUT(4))
      u_sop_logic_array_pal (
      .clk(clk), .rst_n(rst_n), .cfg_we(b_we), .cfg_row(b_row), .cfg_data(b_data),
      .rd_row(b_rd), .rd_data(b_rdd), .in_vec(b_in), .out_vec(b_out));

   int checks = 0;
   int errors = 0;
   logic [5:0] ma_and [8];
   logic [3:0] ma_or  [8];
   logic [5:0] mb_and [16];
   logic [3:0] mb_or  [16];
   logic [31:0] seed = 32'h1234_5678;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic lit(input logic [1:0] c, input logic x);
      case (c)
         2'b00:   return 1'b1;
         2'b10:   return x;
         2'b01:   return !x;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [3:0] eval_a(input logic [2:0] x);
      logic [3:0] r = '0;
      for (int t = 0; t < 8; t++) begin
         logic p = 1'b1;
         for (int i = 0; i < 3; i++) p &= lit(ma_and[t][2*i +: 2], x[i]);
         r |= p ? ma_or[t] : 4'b0;
      end
      return r;
   endfunction

   function automatic logic [3:0] eval_b(input logic [2:0] x);
      logic [3:0] r = '0;
      for (int t = 0; t < 16; t++) begin
         logic p = 1'b1;
         for (int i = 0; i < 3; i++) p &= lit(mb_and[t][2*i +: 2], x[i]);
         if (p && mb_or[t][t/4]) r[t/4] = 1'b1;
      end
      return r;
   endfunction

   function automatic logic [31:0] rnd();
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      return seed;
   endfunction

   task automatic wr_a(input int row, input logic [5:0] a, input logic [3:0] o);
      @(negedge clk); a_we = 1; a_row = 3'(row); a_data = {o, a};
      @(negedge clk); a_we = 0;
      ma_and[row] = a; ma_or[row] = o;
   endtask

   task automatic wr_b(input int row, input logic [5:0] a, input logic [3:0] o);
      @(negedge clk); b_we = 1; b_row = 4'(row); b_data = {o, a};
      @(negedge clk); b_we = 0;
      mb_and[row] = a; mb_or[row] = o;
   endtask

   task automatic sweep_a(input string req);
      for (int x = 0; x < 8; x++) begin
         a_in = 3'(x); #0.2;
         chk(req, {28'd0, a_out}, {28'd0, eval_a(3'(x))});
      end
   endtask

   task automatic sweep_b(input string req);
      for (int x = 0; x < 8; x++) begin
         b_in = 3'(x); #0.2;
         chk(req, {28'd0, b_out}, {28'd0, eval_b(3'(x))});
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      @(negedge clk); @(negedge clk); rst_n = 1;
      for (int t = 0; t < 8; t++) begin ma_and[t] = '0; ma_or[t] = '0; end
      for (int t = 0; t < 16; t++) begin mb_and[t] = '0; mb_or[t] = '0; end
   endtask

   initial begin : watchdog
      #1000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      do_reset();

      // R9: cleared matrix gives zero outputs and zero rows
      for (int x = 0; x < 8; x++) begin
         a_in = 3'(x); b_in = 3'(x); #0.2;
         chk("R9 out after reset", {28'd0, a_out}, 32'd0);
         chk("R9 restricted out after reset", {28'd0, b_out}, 32'd0);
      end
      for (int t = 0; t < 8; t++) begin
         a_rd = 3'(t); #0.2; chk("R9 row cleared", {22'd0, a_rdd}, 32'd0);
      end

      // R10 / R4: shared-term example, A=in0 B=in1 C=in2
      wr_a(0, 6'b00_00_10, 4'b1001);  // A        -> F0, F3
      wr_a(1, 6'b01_01_00, 4'b0101);  // B'C'     -> F0, F2
      wr_a(2, 6'b01_00_10, 4'b0010);  // AC'      -> F1
      wr_a(3, 6'b00_10_10, 4'b0110);  // AB       -> F1, F2
      wr_a(4, 6'b10_01_00, 4'b1000);  // B'C      -> F3
      for (int x = 0; x < 8; x++) begin
         logic A, B, C;
         logic [3:0] f;
         A = x[0]; B = x[1]; C = x[2];
         f[0] = A | (!B & !C);
         f[1] = (A & !C) | (A & B);
         f[2] = (!B & !C) | (A & B);
         f[3] = (!B & C) | A;
         a_in = 3'(x); #0.2;
         chk("R10 example functions", {28'd0, a_out}, {28'd0, f});
      end

      // R6 / R7: write timing and read-back
      @(negedge clk);
      a_rd = 3'd5; a_we = 1; a_row = 3'd5; a_data = 10'b1010_10_01_10; #0.2;
      chk("R6 row unchanged before edge", {22'd0, a_rdd}, 32'd0);
      @(negedge clk); a_we = 0; #0.2;
      chk("R7 read-back after edge", {22'd0, a_rdd}, {22'd0, 10'b1010_10_01_10});
      ma_and[5] = 6'b10_01_10; ma_or[5] = 4'b1010;
      a_row = 3'd5; a_data = 10'b0; @(negedge clk); @(negedge clk); #0.2;
      chk("R6 no write without enable", {22'd0, a_rdd}, {22'd0, 10'b1010_10_01_10});
      sweep_a("R4 after extra term");

      // R3: free term and empty columns
      do_reset();
      wr_a(0, 6'b00_00_00, 4'b0001);
      sweep_a("R3 free term / empty outputs");
      for (int x = 0; x < 8; x++) begin
         a_in = 3'(x); #0.2; chk("R3 direct", {28'd0, a_out}, 32'd1);
      end

      // R2: kill code forces the term low
      for (int i = 0; i < 3; i++) begin
         logic [5:0] k = 6'b11 << (2*i);
         wr_a(0, k, 4'b0001);
         for (int x = 0; x < 8; x++) begin
            a_in = 3'(x); #0.2; chk("R2 kill code", {28'd0, a_out}, 32'd0);
         end
      end

      // R1: single literal per code and input
      for (int i = 0; i < 3; i++) begin
         wr_a(0, 6'b10 << (2*i), 4'b0001);
         for (int x = 0; x < 8; x++) begin
            a_in = 3'(x); #0.2; chk("R1 true literal", {31'd0, a_out[0]}, {31'd0, x[i]});
         end
         wr_a(0, 6'b01 << (2*i), 4'b0001);
         for (int x = 0; x < 8; x++) begin
            a_in = 3'(x); #0.2; chk("R1 complement literal", {31'd0, a_out[0]}, {31'd0, !x[i]});
         end
      end

      // R4 / R5: random matrices, inputs changed between edges
      for (int r = 0; r < 25; r++) begin
         for (int t = 0; t < 8; t++) begin
            logic [31:0] v = rnd();
            wr_a(t, v[5:0], v[9:6]);
         end
         @(negedge clk);
         sweep_a("R4 R5 random matrix");
      end

      // R8: restricted copy drops cross-group connect bits
      wr_b(5, 6'b00_00_00, 4'b1111);
      b_rd = 4'd5; #0.2;
      chk("R8 foreign bits read back 0", {22'd0, b_rdd}, {22'd0, 10'b0010_000000});
      sweep_b("R8 only owner output rises");
      for (int x = 0; x < 8; x++) begin
         b_in = 3'(x); #0.2; chk("R8 direct", {28'd0, b_out}, 32'd2);
      end
      for (int r = 0; r < 20; r++) begin
         for (int t = 0; t < 16; t++) begin
            logic [31:0] v = rnd();
            wr_b(t, v[5:0], v[9:6]);
            b_rd = 4'(t); #0.2;
            chk("R8 masked read-back", {22'd0, b_rdd},
                {22'd0, v[9:6] & 4'(1 << (t/4)), v[5:0]});
         end
         sweep_b("R8 random restricted matrix");
      end

      // R9: reset after programming clears both copies
      do_reset();
      for (int x = 0; x < 8; x++) begin
         a_in = 3'(x); b_in = 3'(x); #0.2;
         chk("R9 cleared again", {28'd0, a_out}, 32'd0);
         chk("R9 restricted cleared again", {28'd0, b_out}, 32'd0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule